// File: doc/BRIEF.md
# Double-Buffered Framed Serial Port

This block is a full-duplex synchronous serial port. It has separate transmit and receive sections, and each section has its own bit clock, frame-sync pin and word length. Each section can take its bit clock and frame sync from pins, or make them from the system clock through a programmable divider. The polarity of the clock and of the frame sync can be set separately for each section. Data always travels most significant bit first.

On the parallel side, software writes words into a transmit holding register. A word moves into the shift register when a frame starts, which frees the holding register for the next word while the current one is still going out. Received words pass through three stages: the shift register, an intermediate buffer, and the readable data register. Two finished words can therefore wait while a third is being shifted in. A word that arrives when both waiting stages are full is dropped, and a sticky overrun flag records the loss.

All serial timing is handled in the system clock domain. The design detects edges on the sampled (or internally generated) bit clock. Bit clock edges must therefore be at least one system clock apart.

Top module: `sport_top`

## Requirements
- R1: The word length is selected per section by a 3-bit code: 0 selects 8 bits, 1 selects 12, 2 selects 16, 3 selects 20, 4 selects 24, and 5 selects 32. Transmit sends the low bits of the written word, MSB first. Receive returns the word right-justified, with zeros above it.
- R2: A write to the transmit register sets the not-ready state (tx_ready low) from the next cycle. The word moves into the shift register on the first launch edge after a frame sync has been seen, and tx_ready then returns high. A new word may be written while the previous one is still shifting, and it is sent in the next frame.
- R3: tx_dat_oe is low after reset and while idle. It goes high at the launch edge that drives the MSB. It goes low again at the launch edge after the last bit.
- R4: A completed received word is placed directly in the data register when that register is empty, and rx_ready goes high. A pulse on rx_rd consumes the word, and rx_ready goes low.
- R5: A word that completes while the data register is still unread waits in the intermediate buffer. It becomes readable right after the next rx_rd.
- R6: A word that completes while both the buffer and the data register are full is discarded, and the two words already held are kept. rx_ovr then goes high and stays high until an ovr_clr pulse.
- R7: With the clock polarity bit at 0, the rising pin edge is the launch edge. With it at 1, the falling pin edge is the launch edge. With the frame polarity bit at 0, frame sync is active high. With it at 1, frame sync is active low.
- R8: Transmit data changes only on launch edges, and receive data is sampled on the opposite (sample) edges. Frame sync is sampled on a sample edge, and the MSB occupies the following bit period.
- R9: An internally generated bit clock has a half period of (div + 1) system clock cycles. When a clock or frame pin is not internally generated, its output is held at 0, which is the state after reset with the configuration inputs at 0.
- R10: An internally generated frame sync is active for one bit period out of every word-length bit periods. The word then follows in the next bit periods.
- R11: After reset, tx_ready is high, and rx_ready and rx_ovr are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_wlen | input | 3 | Transmit word-length code |
| tx_clk_pol | input | 1 | Transmit bit clock polarity |
| tx_fs_pol | input | 1 | Transmit frame sync polarity (1 = active low) |
| tx_clk_int | input | 1 | Transmit bit clock generated internally |
| tx_fs_int | input | 1 | Transmit frame sync generated internally |
| tx_div | input | DIV_W | Transmit clock divider (half period - 1) |
| rx_wlen | input | 3 | Receive word-length code |
| rx_clk_pol | input | 1 | Receive bit clock polarity |
| rx_fs_pol | input | 1 | Receive frame sync polarity (1 = active low) |
| rx_clk_int | input | 1 | Receive bit clock generated internally |
| rx_fs_int | input | 1 | Receive frame sync generated internally |
| rx_div | input | DIV_W | Receive clock divider (half period - 1) |
| tx_wr | input | 1 | Write strobe for the transmit register |
| tx_wdata | input | DW | Transmit word |
| tx_ready | output | 1 | Transmit register empty |
| rx_rd | input | 1 | Read strobe for the receive register |
| rx_rdata | output | DW | Receive data register |
| rx_ready | output | 1 | Receive register holds unread data |
| ovr_clr | input | 1 | Clears the overrun flag |
| rx_ovr | output | 1 | Sticky receive overrun |
| tx_bclk_in | input | 1 | Transmit bit clock pin (external) |
| tx_fs_in | input | 1 | Transmit frame sync pin (external) |
| tx_bclk_out | output | 1 | Generated transmit bit clock |
| tx_fs_out | output | 1 | Generated transmit frame sync |
| tx_dat_o | output | 1 | Serial transmit data |
| tx_dat_oe | output | 1 | Drive enable for tx_dat_o (low = high impedance) |
| rx_bclk_in | input | 1 | Receive bit clock pin (external) |
| rx_fs_in | input | 1 | Receive frame sync pin (external) |
| rx_bclk_out | output | 1 | Generated receive bit clock |
| rx_fs_out | output | 1 | Generated receive frame sync |
| rx_dat_i | input | 1 | Serial receive data |

## Verification
The bench fills the receive path with three words and no read in between. It then checks that the first two are read back in order, that the third is gone, and that the overrun flag stays set until it is cleared. A design that overwrote the buffer would return the third word, and a design that lost the buffer stage would return nothing after the first read. On the transmit side, the next word is written while the current one is still being shifted out. A design without the double buffer would corrupt the bits still going out on the wire, or would never show tx_ready. Every word length code, and inverted clock and frame polarity on both sections, is exercised against frames built bit by bit. The internal clock is measured for its half period, and the internal frame sync for its spacing.

// File: rtl/sport_pkg.sv
package sport_pkg;

    // Per-section configuration carried to the timing logic.
    typedef struct packed {
        logic ck_pol;
        logic fs_pol;
        logic ck_int;
        logic fs_int;
    } sec_cfg_t;

    // Per-cycle serial events for one section.
    typedef struct packed {
        logic launch;
        logic sample;
        logic fs;
    } sec_evt_t;

    // Word length in bits for a 3-bit length code.
    function automatic logic [5:0] wlen_bits(input logic [2:0] code);
        case (code)
            3'd0:    return 6'd8;
            3'd1:    return 6'd12;
            3'd2:    return 6'd16;
            3'd3:    return 6'd20;
            3'd4:    return 6'd24;
            default: return 6'd32;
        endcase
    endfunction

endpackage

// File: rtl/sport_clkdiv.sv
module sport_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             ck
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            ck  <= 1'b0;
        end else if (cnt == div) begin
            cnt <= '0;
            ck  <= ~ck;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sport_timing.sv
module sport_timing
    import sport_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  sec_cfg_t cfg,
    input  logic     ck_pin,
    input  logic     fs_pin,
    input  logic [5:0] last,
    output sec_evt_t evt,
    output logic     fs_gen
);
    logic       eff;
    logic       eff_q;
    logic [5:0] fcnt;
    logic [5:0] fnext;

    assign eff   = ck_pin ^ cfg.ck_pol;
    assign fnext = (fcnt == last) ? 6'd0 : fcnt + 6'd1;

    always_comb begin
        evt.launch = eff & ~eff_q;
        evt.sample = ~eff & eff_q;
        evt.fs     = cfg.fs_int ? fs_gen : (fs_pin ^ cfg.fs_pol);
    end

    always_ff @(posedge clk) begin
        if (rst) eff_q <= 1'b0;
        else     eff_q <= eff;
    end

    // Frame generator: active during the last bit period of each frame slot.
    always_ff @(posedge clk) begin
        if (rst || !cfg.fs_int) begin
            fcnt   <= '0;
            fs_gen <= 1'b0;
        end else if (evt.launch) begin
            fcnt   <= fnext;
            fs_gen <= (fnext == last);
        end
    end
endmodule

// File: rtl/sport_tx.sv
module sport_tx
    import sport_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  sec_evt_t      evt,
    input  logic [5:0]    last,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic          ready,
    output logic          dat,
    output logic          oe
);
    logic [DW-1:0] hold;
    logic [DW-1:0] sr;
    logic          full;
    logic          go;
    logic [5:0]    cnt;
    logic [5:0]    sh;

    assign sh    = 6'(DW - 1) - last;
    assign ready = ~full;
    assign dat   = oe & sr[DW-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
            sr   <= '0;
            full <= 1'b0;
            go   <= 1'b0;
            oe   <= 1'b0;
            cnt  <= '0;
        end else begin
            if (evt.sample && evt.fs)
                go <= full;
            if (evt.launch && go) begin
                sr   <= hold << sh;
                go   <= 1'b0;
                oe   <= 1'b1;
                cnt  <= '0;
                full <= 1'b0;
            end else if (evt.launch && oe) begin
                if (cnt == last) begin
                    oe <= 1'b0;
                end else begin
                    sr  <= sr << 1;
                    cnt <= cnt + 6'd1;
                end
            end
            if (wr) begin
                hold <= wdata;
                full <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sport_rx.sv
module sport_rx
    import sport_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  sec_evt_t      evt,
    input  logic [5:0]    last,
    input  logic          din,
    input  logic          rd,
    input  logic          ovr_clr,
    output logic [DW-1:0] rdata,
    output logic          ready,
    output logic          buf_full,
    output logic          ovr
);
    logic [DW-1:0] sr;
    logic [DW-1:0] shifted;
    logic [DW-1:0] rbuf;
    logic [5:0]    cnt;
    logic          busy;
    logic          done;
    logic          rdr_free;

    assign shifted  = {sr[DW-2:0], din};
    assign done     = evt.sample & busy & (cnt == last);
    assign rdr_free = ~ready | rd;

    // Shift stage
    always_ff @(posedge clk) begin
        if (rst) begin
            sr   <= '0;
            cnt  <= '0;
            busy <= 1'b0;
        end else if (evt.sample) begin
            if (busy) begin
                sr <= shifted;
                if (cnt == last) busy <= 1'b0;
                else             cnt  <= cnt + 6'd1;
            end
            if (evt.fs && (!busy || cnt == last)) begin
                busy <= 1'b1;
                cnt  <= '0;
                sr   <= '0;
            end
        end
    end

    // Buffer and data register stages
    always_ff @(posedge clk) begin
        if (rst) begin
            rbuf     <= '0;
            buf_full <= 1'b0;
            rdata    <= '0;
            ready    <= 1'b0;
            ovr      <= 1'b0;
        end else begin
            if (ovr_clr) ovr <= 1'b0;
            if (buf_full) begin
                if (rdr_free) begin
                    rdata    <= rbuf;
                    ready    <= 1'b1;
                    buf_full <= done;
                    if (done) rbuf <= shifted;
                end else if (done) begin
                    ovr <= 1'b1;
                end
            end else if (done) begin
                if (rdr_free) begin
                    rdata <= shifted;
                    ready <= 1'b1;
                end else begin
                    rbuf     <= shifted;
                    buf_full <= 1'b1;
                end
            end else if (rd) begin
                ready <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sport_top.sv
module sport_top
    import sport_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       tx_wlen,
    input  logic             tx_clk_pol,
    input  logic             tx_fs_pol,
    input  logic             tx_clk_int,
    input  logic             tx_fs_int,
    input  logic [DIV_W-1:0] tx_div,
    input  logic [2:0]       rx_wlen,
    input  logic             rx_clk_pol,
    input  logic             rx_fs_pol,
    input  logic             rx_clk_int,
    input  logic             rx_fs_int,
    input  logic [DIV_W-1:0] rx_div,
    input  logic             tx_wr,
    input  logic [DW-1:0]    tx_wdata,
    output logic             tx_ready,
    input  logic             rx_rd,
    output logic [DW-1:0]    rx_rdata,
    output logic             rx_ready,
    input  logic             ovr_clr,
    output logic             rx_ovr,
    input  logic             tx_bclk_in,
    input  logic             tx_fs_in,
    output logic             tx_bclk_out,
    output logic             tx_fs_out,
    output logic             tx_dat_o,
    output logic             tx_dat_oe,
    input  logic             rx_bclk_in,
    input  logic             rx_fs_in,
    output logic             rx_bclk_out,
    output logic             rx_fs_out,
    input  logic             rx_dat_i
);
    sec_cfg_t   tx_cfg, rx_cfg;
    sec_evt_t   tx_evt, rx_evt;
    logic [5:0] tx_last, rx_last;
    logic       tx_ck, rx_ck, tx_fs_gen, rx_fs_gen;
    logic       tx_launch, rx_buf_full;

    assign tx_cfg  = '{ck_pol: tx_clk_pol, fs_pol: tx_fs_pol, ck_int: tx_clk_int, fs_int: tx_fs_int};
    assign rx_cfg  = '{ck_pol: rx_clk_pol, fs_pol: rx_fs_pol, ck_int: rx_clk_int, fs_int: rx_fs_int};
    assign tx_last = wlen_bits(tx_wlen) - 6'd1;
    assign rx_last = wlen_bits(rx_wlen) - 6'd1;

    assign tx_bclk_out = tx_clk_int & (tx_ck ^ tx_clk_pol);
    assign rx_bclk_out = rx_clk_int & (rx_ck ^ rx_clk_pol);
    assign tx_fs_out   = tx_fs_int & (tx_fs_gen ^ tx_fs_pol);
    assign rx_fs_out   = rx_fs_int & (rx_fs_gen ^ rx_fs_pol);
    assign tx_launch   = tx_evt.launch;

    sport_clkdiv #(.DIV_W(DIV_W)) u_tx_div (
        .clk(clk), .rst(rst), .en(tx_clk_int), .div(tx_div), .ck(tx_ck));
    sport_clkdiv #(.DIV_W(DIV_W)) u_rx_div (
        .clk(clk), .rst(rst), .en(rx_clk_int), .div(rx_div), .ck(rx_ck));

    sport_timing u_tx_tim (
        .clk(clk), .rst(rst), .cfg(tx_cfg),
        .ck_pin(tx_clk_int ? tx_bclk_out : tx_bclk_in),
        .fs_pin(tx_fs_in), .last(tx_last), .evt(tx_evt), .fs_gen(tx_fs_gen));
    sport_timing u_rx_tim (
        .clk(clk), .rst(rst), .cfg(rx_cfg),
        .ck_pin(rx_clk_int ? rx_bclk_out : rx_bclk_in),
        .fs_pin(rx_fs_in), .last(rx_last), .evt(rx_evt), .fs_gen(rx_fs_gen));

    sport_tx #(.DW(DW)) u_tx (
        .clk(clk), .rst(rst), .evt(tx_evt), .last(tx_last),
        .wr(tx_wr), .wdata(tx_wdata), .ready(tx_ready),
        .dat(tx_dat_o), .oe(tx_dat_oe));

    sport_rx #(.DW(DW)) u_rx (
        .clk(clk), .rst(rst), .evt(rx_evt), .last(rx_last),
        .din(rx_dat_i), .rd(rx_rd), .ovr_clr(ovr_clr),
        .rdata(rx_rdata), .ready(rx_ready), .buf_full(rx_buf_full), .ovr(rx_ovr));
endmodule

// File: rtl/sport_chk.sv
module sport_chk (
    input logic clk,
    input logic rst,
    input logic tx_wr,
    input logic tx_ready,
    input logic tx_dat_o,
    input logic tx_dat_oe,
    input logic tx_launch,
    input logic rx_ready,
    input logic rx_buf_full,
    input logic rx_ovr,
    input logic ovr_clr
);
    p_wr_busy_r2: assert property (@(posedge clk) disable iff (rst)
        tx_wr |=> !tx_ready);

    p_oe_on_launch_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_dat_oe) |-> $past(tx_launch));

    p_dat_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !tx_launch |=> $stable(tx_dat_o));

    p_buf_behind_rdr_r5: assert property (@(posedge clk) disable iff (rst)
        rx_buf_full |-> rx_ready);

    p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (rx_ovr && !ovr_clr) |=> rx_ovr);

    p_ovr_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_ovr) |-> $past(rx_buf_full && rx_ready));
endmodule

bind sport_top sport_chk u_chk (
    .clk(clk), .rst(rst), .tx_wr(tx_wr), .tx_ready(tx_ready),
    .tx_dat_o(tx_dat_o), .tx_dat_oe(tx_dat_oe), .tx_launch(tx_launch),
    .rx_ready(rx_ready), .rx_buf_full(rx_buf_full), .rx_ovr(rx_ovr),
    .ovr_clr(ovr_clr));

// File: tb/sport_top_tb.sv
module sport_top_tb;
    localparam int H = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  tx_wlen = 3'd0, rx_wlen = 3'd0;
    logic        tx_clk_pol = 0, tx_fs_pol = 0, tx_clk_int = 0, tx_fs_int = 0;
    logic        rx_clk_pol = 0, rx_fs_pol = 0, rx_clk_int = 0, rx_fs_int = 0;
    logic [7:0]  tx_div = 8'd0, rx_div = 8'd0;
    logic        tx_wr = 0, rx_rd = 0, ovr_clr = 0;
    logic [31:0] tx_wdata = '0;
    logic        tx_bclk_in = 0, tx_fs_in = 0, rx_bclk_in = 0, rx_fs_in = 0, rx_dat_i = 0;
    logic        tx_ready, rx_ready, rx_ovr;
    logic [31:0] rx_rdata;
    logic        tx_bclk_out, tx_fs_out, tx_dat_o, tx_dat_oe, rx_bclk_out, rx_fs_out;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sport_top u_dut (
        .clk(clk), .rst(rst),
        .tx_wlen(tx_wlen), .tx_clk_pol(tx_clk_pol), .tx_fs_pol(tx_fs_pol),
        .tx_clk_int(tx_clk_int), .tx_fs_int(tx_fs_int), .tx_div(tx_div),
        .rx_wlen(rx_wlen), .rx_clk_pol(rx_clk_pol), .rx_fs_pol(rx_fs_pol),
        .rx_clk_int(rx_clk_int), .rx_fs_int(rx_fs_int), .rx_div(rx_div),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_ready(tx_ready),
        .rx_rd(rx_rd), .rx_rdata(rx_rdata), .rx_ready(rx_ready),
        .ovr_clr(ovr_clr), .rx_ovr(rx_ovr),
        .tx_bclk_in(tx_bclk_in), .tx_fs_in(tx_fs_in), .tx_bclk_out(tx_bclk_out),
        .tx_fs_out(tx_fs_out), .tx_dat_o(tx_dat_o), .tx_dat_oe(tx_dat_oe),
        .rx_bclk_in(rx_bclk_in), .rx_fs_in(rx_fs_in), .rx_bclk_out(rx_bclk_out),
        .rx_fs_out(rx_fs_out), .rx_dat_i(rx_dat_i));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        tx_bclk_in = tx_clk_pol; tx_fs_in = tx_fs_pol;
        rx_bclk_in = rx_clk_pol; rx_fs_in = rx_fs_pol;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // One receive bit period: launch (rise) with fs/data, then sample (fall).
    task automatic rx_bit(input logic fsv, input logic dv);
        rx_bclk_in = 1'b1 ^ rx_clk_pol;
        rx_fs_in   = fsv ^ rx_fs_pol;
        rx_dat_i   = dv;
        repeat (H) @(negedge clk);
        rx_bclk_in = rx_clk_pol;
        repeat (H) @(negedge clk);
    endtask

    task automatic rx_send(input logic [31:0] w, input int bits);
        rx_bit(1'b1, 1'b0);
        for (int i = bits - 1; i >= 0; i--) rx_bit(1'b0, w[i]);
        repeat (4) @(negedge clk);
    endtask

    task automatic rd_pulse();
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
        @(negedge clk);
    endtask

    // One transmit bit period; samples tx pins just before the sample edge.
    task automatic tx_bit(input logic fsv, input logic do_wr, input logic [31:0] wd,
                          output logic dv, output logic oev);
        tx_bclk_in = 1'b1 ^ tx_clk_pol;
        tx_fs_in   = fsv ^ tx_fs_pol;
        if (do_wr) begin tx_wr = 1'b1; tx_wdata = wd; end
        @(negedge clk);
        tx_wr = 1'b0;
        repeat (H - 1) @(negedge clk);
        dv  = tx_dat_o;
        oev = tx_dat_oe;
        tx_bclk_in = tx_clk_pol;
        repeat (H) @(negedge clk);
    endtask

    // Frame sync bit, then 'bits' data bits; optional mid-frame write.
    task automatic tx_frame(input int bits, input int wr_at, input logic [31:0] wd,
                            output logic [31:0] w, output logic oe_all);
        logic dv, oev;
        w = '0; oe_all = 1'b1;
        tx_bit(1'b1, 1'b0, '0, dv, oev);
        for (int i = 0; i < bits; i++) begin
            tx_bit(1'b0, i == wr_at, wd, dv, oev);
            w = {w[30:0], dv};
            oe_all &= oev;
            if (i == wr_at) check("R2 ready low after mid-frame write", {31'd0, tx_ready}, 32'd0);
        end
    endtask

    task automatic tx_idle_bit(input string req);
        logic dv, oev;
        tx_bit(1'b0, 1'b0, '0, dv, oev);
        check(req, {31'd0, oev}, 32'd0);
    endtask

    task automatic tx_write(input logic [31:0] wd);
        tx_wr = 1'b1; tx_wdata = wd;
        @(negedge clk);
        tx_wr = 1'b0;
        check("R2 ready low after write", {31'd0, tx_ready}, 32'd0);
    endtask

    task automatic t_reset();
        do_reset();
        check("R11 tx_ready after reset", {31'd0, tx_ready}, 32'd1);
        check("R11 rx_ready after reset", {31'd0, rx_ready}, 32'd0);
        check("R11 rx_ovr after reset", {31'd0, rx_ovr}, 32'd0);
        check("R3 oe low after reset", {31'd0, tx_dat_oe}, 32'd0);
        check("R9 external pins held 0", {28'd0, tx_bclk_out, tx_fs_out, rx_bclk_out, rx_fs_out}, 32'd0);
    endtask

    task automatic t_tx_double();
        logic [31:0] w;
        logic oe_all;
        tx_wlen = 3'd2;
        do_reset();
        tx_write(32'h0000A5C3);
        tx_frame(16, 5, 32'h00003C69, w, oe_all);
        check("R1 R8 first tx word 16b", w, 32'h0000A5C3);
        check("R3 oe high during bits", {31'd0, oe_all}, 32'd1);
        tx_idle_bit("R3 oe low after last bit");
        tx_frame(16, -1, '0, w, oe_all);
        check("R2 word written mid-frame sent next", w, 32'h00003C69);
        check("R2 ready after load", {31'd0, tx_ready}, 32'd1);
        tx_idle_bit("R3 oe low when idle");
    endtask

    task automatic t_tx_len(input logic [2:0] code, input int bits,
                            input logic [31:0] wd, input logic [31:0] exp);
        logic [31:0] w;
        logic oe_all;
        tx_wlen = code;
        do_reset();
        tx_write(wd);
        tx_frame(bits, -1, '0, w, oe_all);
        check($sformatf("R1 tx length code %0d", code), w, exp);
        tx_idle_bit("R3 oe low after word");
    endtask

    task automatic t_rx_basic();
        rx_wlen = 3'd1;
        do_reset();
        rx_send(32'h00000A5B, 12);
        check("R4 rx_ready after word", {31'd0, rx_ready}, 32'd1);
        check("R1 R4 rx 12b right-justified", rx_rdata, 32'h00000A5B);
        rd_pulse();
        check("R4 rx_ready cleared by read", {31'd0, rx_ready}, 32'd0);
        rx_wlen = 3'd5;
        do_reset();
        rx_send(32'hC0FFEE11, 32);
        check("R1 rx 32b word", rx_rdata, 32'hC0FFEE11);
    endtask

    task automatic t_rx_stage();
        rx_wlen = 3'd0;
        do_reset();
        rx_send(32'h11, 8);
        rx_send(32'h22, 8);
        check("R5 first word still readable", rx_rdata, 32'h11);
        check("R6 no overrun with two held", {31'd0, rx_ovr}, 32'd0);
        rx_send(32'h33, 8);
        check("R6 overrun set", {31'd0, rx_ovr}, 32'd1);
        check("R6 first word kept", rx_rdata, 32'h11);
        rd_pulse();
        check("R5 buffered word after read", rx_rdata, 32'h22);
        check("R5 ready stays high", {31'd0, rx_ready}, 32'd1);
        rd_pulse();
        check("R6 third word dropped", {31'd0, rx_ready}, 32'd0);
        check("R6 overrun sticky", {31'd0, rx_ovr}, 32'd1);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        check("R6 overrun cleared", {31'd0, rx_ovr}, 32'd0);
    endtask

    task automatic t_pol();
        logic [31:0] w;
        logic oe_all;
        tx_clk_pol = 1; tx_fs_pol = 1; rx_clk_pol = 1; rx_fs_pol = 1;
        tx_wlen = 3'd0; rx_wlen = 3'd0;
        do_reset();
        rx_send(32'h5A, 8);
        check("R7 rx with inverted polarities", rx_rdata, 32'h5A);
        tx_write(32'hC3);
        tx_frame(8, -1, '0, w, oe_all);
        check("R7 tx with inverted polarities", w, 32'hC3);
        tx_clk_pol = 0; tx_fs_pol = 0; rx_clk_pol = 0; rx_fs_pol = 0;
    endtask

    task automatic t_internal();
        int cyc = 0, half = 0, toggles = 0, falls = 0, f1 = -1, f2 = -1, nb = -1;
        logic pb;
        logic [7:0] w = '0;
        tx_clk_int = 1; tx_fs_int = 1; tx_div = 8'd2; tx_wlen = 3'd0;
        do_reset();
        tx_write(32'h96);
        pb = tx_bclk_out;
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            cyc++;
            if (tx_bclk_out !== pb) begin
                toggles++;
                if (toggles == 3) half = cyc;
                cyc = 0;
                if (pb == 1'b1) begin
                    falls++;
                    if (nb >= 0 && nb < 8) begin w = {w[6:0], tx_dat_o}; nb++; end
                    if (tx_fs_out) begin
                        if (f1 < 0) begin f1 = falls; nb = 0; end
                        else if (f2 < 0) f2 = falls;
                    end
                end
                pb = tx_bclk_out;
            end
        end
        check("R9 internal half period", half, 3);
        check("R10 internal frame spacing", f2 - f1, 8);
        check("R10 word after internal frame sync", {24'd0, w}, 32'h96);
        tx_clk_int = 0; tx_fs_int = 0;
        rx_clk_int = 1; rx_div = 8'd0;
        do_reset();
        cyc = 0; half = 0; toggles = 0;
        pb = rx_bclk_out;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            cyc++;
            if (rx_bclk_out !== pb) begin
                toggles++;
                if (toggles == 3) half = cyc;
                cyc = 0;
                pb = rx_bclk_out;
            end
        end
        check("R9 fastest internal half period", half, 1);
        rx_clk_int = 0;
    endtask

    initial begin
        t_reset();
        t_tx_double();
        t_tx_len(3'd0, 8,  32'h1234569B, 32'h9B);
        t_tx_len(3'd3, 20, 32'hF00ABCDE, 32'h000ABCDE);
        t_tx_len(3'd4, 24, 32'h00817263, 32'h00817263);
        t_tx_len(3'd5, 32, 32'hDEADBEEF, 32'hDEADBEEF);
        t_rx_basic();
        t_rx_stage();
        t_pol();
        t_internal();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule